// File: doc/BRIEF.md
# Configurable Quadrature Pulse Counter

This block turns pulse trains on two external inputs, A and B, into a signed, wrap-around position count. Each input is first brought into the system clock domain by a two-flop synchronizer. It then passes through a glitch filter whose hold time is set in clock cycles. The filtered levels feed an edge decoder, which drives a single up/down counter.

Four counting modes are available:
- **Single-phase:** only A is used, and a direction bit picks up or down.
- **Two-phase 1x, 2x and 4x:** these read A and B as a quadrature pair and count one, two or four steps per full signal cycle.

An enable input starts and stops counting. A comparison flag reports whether the count has reached a programmable set value. In the two-phase 2x and 4x modes, a clock in which both inputs change cannot be decoded. Such a clock is discarded and latched in a sticky error bit.

Configuration is presented on static input ports. Upstream logic is expected to hold these values in its own registers. The count width, the filter field width and the synchronizer depth are parameters.

Top module: `qpc_counter`

## Requirements
- R1: While `rstN` is low and after its release, `count` is 0, `cmpHit` is 0 and `seqErr` is 0.
- R2: With `cfgMode` = 1 (1x), a filtered rise of B while A is high adds one. A filtered fall of B while A is high subtracts one. No other edge changes the count, so one forward cycle gives +1 and one reverse cycle gives -1.
- R3: With `cfgMode` = 2 (2x), the R2 rules apply. In addition, a fall of B while A is low adds one and a rise of B while A is low subtracts one. One full cycle therefore gives +2 forward and -2 reverse.
- R4: With `cfgMode` = 3 (4x), every single-input edge counts.
  - Up: A rising with B low, B rising with A high, A falling with B high, B falling with A low.
  - Down: the four mirror cases.
- R5: With `cfgMode` = 0 (single-phase), each rising edge of A moves the count by one. The move is up when `cfgDown` = 0 and down when `cfgDown` = 1. Input B has no effect in this mode.
- R6: The count is a two's-complement ring of `CNT_W` bits. Incrementing the maximum positive value gives the most negative value, and decrementing the most negative value gives the maximum positive value.
- R7: While `en` is low, `count` and `cmpHit` hold their values whatever the inputs or the set value do.
- R8: While `en` is high, `cmpHit` is 1 exactly when the signed count is greater than or equal to the signed `cfgSetVal`, and 0 otherwise.
- R9: A filtered input level changes only after the synchronized level has differed from it for `cfgFilt`+1 consecutive clocks. Shorter pulses are dropped. A setting of 0 accepts a one-clock pulse.
- R10: In 2x and 4x modes, a clock in which both filtered inputs change leaves the count unchanged and sets `seqErr`. Only reset clears `seqErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| inA | input | 1 | Raw phase A / single-phase pulse input |
| inB | input | 1 | Raw phase B input |
| cfgMode | input | 2 | 0 single-phase, 1 1x, 2 2x, 3 4x |
| cfgDown | input | 1 | Single-phase direction, 1 = down |
| cfgFilt | input | FILT_W | Filter hold time in clock cycles |
| cfgSetVal | input | CNT_W | Signed comparison set value |
| count | output | CNT_W | Signed count value |
| cmpHit | output | 1 | Count at or above set value |
| seqErr | output | 1 | Sticky simultaneous-change error |

## Verification
The bench builds the block with `CNT_W` = 8, so both ring crossings (127 to -128 and back) can be reached with a few hundred quadrature steps. With the 32-bit default, the same crossings would need billions of pulses. `FILT_W` keeps its default of 11 bits. This lets the bench program a filter hold of 10 clocks, then show a 5-clock pulse dropped and a 20-clock pulse counted, and finally show a single-clock pulse counted once the setting is 0.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_X1     = 2'd1,
    MODE_X2     = 2'd2,
    MODE_X4     = 2'd3
  } qpc_mode_e;

  // strobes from the decode control to the counting datapath
  typedef struct packed {
    logic live;   // enable is high this clock
    logic inc;    // add one
    logic dec;    // subtract one
    logic bad;    // undecodable double change
  } qpc_strobe_t;

endpackage

// File: rtl/qpc_infilt.sv
module qpc_infilt #(
  parameter int FILT_W  = 11,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic [FILT_W-1:0] cfgFilt,
  output logic              level
);

  localparam logic [FILT_W-1:0] ONE_F = FILT_W'(1);

  logic [SYNC_N-1:0] syncQ;
  logic              syncLvl;
  logic [FILT_W-1:0] runLen;

  assign syncLvl = syncQ[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      level  <= 1'b0;
      runLen <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_N-2:0], rawIn};
      if (syncLvl == level) begin
        runLen <= '0;
      end else if (runLen >= cfgFilt) begin
        level  <= syncLvl;
        runLen <= '0;
      end else begin
        runLen <= runLen + ONE_F;
      end
    end
  end

  // R9: a filtered change follows a clock where the synchronized level differed
  p_filt_settle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> ($past(syncLvl) != $past(level)));

endmodule

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        en,
  input  logic        aLvl,
  input  logic        bLvl,
  input  qpc_mode_e   mode,
  input  logic        cfgDown,
  output qpc_strobe_t strb
);

  logic aPrev, bPrev;
  logic aRise, aFall, bRise, bFall, aChg, bChg;
  logic up, dn, dbl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aPrev <= 1'b0;
      bPrev <= 1'b0;
    end else begin
      aPrev <= aLvl;
      bPrev <= bLvl;
    end
  end

  assign aChg  = aLvl ^ aPrev;
  assign bChg  = bLvl ^ bPrev;
  assign aRise = aChg & aLvl;
  assign aFall = aChg & ~aLvl;
  assign bRise = bChg & bLvl;
  assign bFall = bChg & ~bLvl;

  always_comb begin
    up  = 1'b0;
    dn  = 1'b0;
    dbl = 1'b0;
    unique case (mode)
      MODE_SINGLE: begin
        up = aRise & ~cfgDown;
        dn = aRise & cfgDown;
      end
      MODE_X1: begin
        up = bRise & aLvl;
        dn = bFall & aLvl;
      end
      MODE_X2: begin
        dbl = aChg & bChg;
        up  = (bRise & aLvl) | (bFall & ~aLvl);
        dn  = (bFall & aLvl) | (bRise & ~aLvl);
      end
      MODE_X4: begin
        dbl = aChg & bChg;
        up  = (aRise & ~bLvl) | (bRise & aLvl) | (aFall & bLvl) | (bFall & ~aLvl);
        dn  = (bRise & ~aLvl) | (aRise & bLvl) | (bFall & aLvl) | (aFall & ~bLvl);
      end
      default: ;
    endcase
  end

  always_comb begin
    strb.live = en;
    strb.bad  = en & dbl;
    strb.inc  = en & up & ~dbl;
    strb.dec  = en & dn & ~dbl;
  end

  // R10: never more than one of count-up, count-down, error in a clock
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.inc, strb.dec, strb.bad}));

  // R5: in single-phase mode nothing counts without an A change
  p_single_a_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SINGLE && !aChg) |-> (!strb.inc && !strb.dec));

endmodule

// File: rtl/qpc_dpath.sv
module qpc_dpath
  import qpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpc_strobe_t      strb,
  input  logic [CNT_W-1:0] cfgSetVal,
  output logic [CNT_W-1:0] count,
  output logic             cmpHit,
  output logic             seqErr
);

  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = count;
    if (strb.inc)      nxt = count + ONE_C;
    else if (strb.dec) nxt = count - ONE_C;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      cmpHit <= 1'b0;
      seqErr <= 1'b0;
    end else begin
      count  <= nxt;
      if (strb.live) cmpHit <= ($signed(nxt) >= $signed(cfgSetVal));
      if (strb.bad)  seqErr <= 1'b1;
    end
  end

  // R7: disabled clock leaves count and flag untouched
  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.live |=> ($stable(count) && $stable(cmpHit)));

  // R6: the ring moves by at most one step per clock, modulo 2^CNT_W
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((count == $past(count)) || (count == $past(count) + ONE_C)
              || (count == $past(count) - ONE_C)));

  // R10: error bit is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr);

  // R8: after an enabled clock the flag matches the new count
  p_flag_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.live |=> (cmpHit == ($signed(count) >= $signed($past(cfgSetVal)))));

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FILT_W = 11,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              inA,
  input  logic              inB,
  input  logic [1:0]        cfgMode,
  input  logic              cfgDown,
  input  logic [FILT_W-1:0] cfgFilt,
  input  logic [CNT_W-1:0]  cfgSetVal,
  output logic [CNT_W-1:0]  count,
  output logic              cmpHit,
  output logic              seqErr
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] filtLvl;
  qpc_strobe_t     strb;

  assign rawIn = {inB, inA};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    qpc_infilt #(
      .FILT_W (FILT_W),
      .SYNC_N (SYNC_N)
    ) i_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawIn[gi]),
      .cfgFilt (cfgFilt),
      .level   (filtLvl[gi])
    );
  end

  qpc_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .aLvl    (filtLvl[0]),
    .bLvl    (filtLvl[1]),
    .mode    (qpc_mode_e'(cfgMode)),
    .cfgDown (cfgDown),
    .strb    (strb)
  );

  qpc_dpath #(
    .CNT_W (CNT_W)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgSetVal (cfgSetVal),
    .count     (count),
    .cmpHit    (cmpHit),
    .seqErr    (seqErr)
  );

endmodule

// File: tb/test_qpc_counter.sv
module test_qpc_counter;

  localparam int CNT_W  = 8;
  localparam int FILT_W = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              en = 1'b0;
  logic              inA = 1'b0;
  logic              inB = 1'b0;
  logic [1:0]        cfgMode = 2'd0;
  logic              cfgDown = 1'b0;
  logic [FILT_W-1:0] cfgFilt = '0;
  logic [CNT_W-1:0]  cfgSetVal = 8'd100;
  logic [CNT_W-1:0]  count;
  logic              cmpHit;
  logic              seqErr;

  int nChk = 0;
  int nBad = 0;
  int curFilt = 0;
  logic signed [CNT_W-1:0] expCnt = '0;

  always #2.5 clk = ~clk;

  qpc_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) i_qpc_counter (
    .clk(clk), .rstN(rstN), .en(en), .inA(inA), .inB(inB),
    .cfgMode(cfgMode), .cfgDown(cfgDown), .cfgFilt(cfgFilt),
    .cfgSetVal(cfgSetVal), .count(count), .cmpHit(cmpHit), .seqErr(seqErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive both inputs, wait for the change to reach the count, update model
  task automatic drive(input logic a, input logic b, input int delta);
    @(negedge clk);
    inA = a;
    inB = b;
    idle(curFilt + 8);
    expCnt = expCnt + CNT_W'(delta);
  endtask

  function automatic int fwdDelta(input int m, input int idx);
    // forward order 00->10->11->01->00
    if (m == 3) return 1;
    if (m == 2) return (idx == 1 || idx == 3) ? 1 : 0;
    return (idx == 1) ? 1 : 0;
  endfunction

  task automatic quadFwd(input int m);
    drive(1, 0, fwdDelta(m, 0));
    drive(1, 1, fwdDelta(m, 1));
    drive(0, 1, fwdDelta(m, 2));
    drive(0, 0, fwdDelta(m, 3));
  endtask

  task automatic quadRev(input int m);
    // reverse order 00->01->11->10->00
    drive(0, 1, (m == 3 || m == 2) ? -1 : 0);
    drive(1, 1, (m == 3) ? -1 : 0);
    drive(1, 0, -1);
    drive(0, 0, (m == 3) ? -1 : 0);
  endtask

  task automatic pulseA(input int width, input int delta);
    @(negedge clk);
    inA = 1'b1;
    idle(width);
    inA = 1'b0;
    idle(curFilt + 8);
    expCnt = expCnt + CNT_W'(delta);
  endtask

  task automatic t_reset;
    chk("R1 count in reset", count, 0);
    chk("R1 cmpHit in reset", cmpHit, 0);
    chk("R1 seqErr in reset", seqErr, 0);
    rstN = 1'b1;
    idle(3);
    chk("R1 count after reset", count, 0);
    chk("R1 seqErr after reset", seqErr, 0);
    en = 1'b1;
  endtask

  task automatic t_single;
    cfgMode = 2'd0;
    cfgDown = 1'b0;
    for (int i = 0; i < 3; i++) pulseA(3, 1);
    chk("R5 single up three pulses", $signed(count), expCnt);
    drive(0, 1, 0);
    drive(0, 0, 0);
    chk("R5 B ignored in single mode", $signed(count), expCnt);
    cfgDown = 1'b1;
    for (int i = 0; i < 2; i++) pulseA(3, -1);
    chk("R5 single down two pulses", $signed(count), expCnt);
    cfgDown = 1'b0;
  endtask

  task automatic t_x1;
    cfgMode = 2'd1;
    quadFwd(1); quadFwd(1);
    chk("R2 1x forward", $signed(count), expCnt);
    quadRev(1);
    chk("R2 1x reverse", $signed(count), expCnt);
  endtask

  task automatic t_x2;
    cfgMode = 2'd2;
    quadFwd(2); quadFwd(2);
    chk("R3 2x forward", $signed(count), expCnt);
    quadRev(2);
    chk("R3 2x reverse", $signed(count), expCnt);
  endtask

  task automatic t_x4;
    cfgMode = 2'd3;
    quadFwd(3);
    chk("R4 4x forward", $signed(count), expCnt);
    quadRev(3); quadRev(3);
    chk("R4 4x reverse", $signed(count), expCnt);
  endtask

  task automatic t_compare;
    cfgMode = 2'd1;
    cfgSetVal = CNT_W'(expCnt + 1);
    idle(3);
    chk("R8 below set value", cmpHit, 0);
    quadFwd(1);
    chk("R8 equal to set value", cmpHit, 1);
    quadFwd(1);
    chk("R8 above set value", cmpHit, 1);
    quadRev(1); quadRev(1);
    chk("R8 back below set value", cmpHit, 0);
    cfgSetVal = 8'sd0 - 8'sd100;
    idle(3);
    chk("R8 signed negative set value", cmpHit, 1);
  endtask

  task automatic t_enable;
    logic flagBefore;
    logic [CNT_W-1:0] cntBefore;
    cfgMode = 2'd3;
    idle(2);
    en = 1'b0;
    flagBefore = cmpHit;
    cntBefore = count;
    cfgSetVal = 8'd50;
    quadFwd(3);
    expCnt = $signed(cntBefore);
    chk("R7 count held while disabled", count, cntBefore);
    chk("R7 flag held while disabled", cmpHit, flagBefore);
    en = 1'b1;
    idle(3);
    chk("R8 flag updates on re-enable", cmpHit, ($signed(count) >= 50) ? 1 : 0);
  endtask

  task automatic t_filter;
    cfgMode = 2'd0;
    cfgDown = 1'b0;
    curFilt = 10;
    cfgFilt = FILT_W'(10);
    idle(4);
    pulseA(5, 0);
    chk("R9 short pulse dropped", $signed(count), expCnt);
    pulseA(20, 1);
    chk("R9 long pulse counted", $signed(count), expCnt);
    curFilt = 0;
    cfgFilt = '0;
    idle(4);
    pulseA(1, 1);
    chk("R9 one-clock pulse at zero setting", $signed(count), expCnt);
  endtask

  task automatic t_wrap;
    int misses = 0;
    int upSeen = 0;
    int dnSeen = 0;
    cfgMode = 2'd3;
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic signed [CNT_W-1:0] prev;
        prev = expCnt;
        case (k)
          0: drive(1, 0, 1);
          1: drive(1, 1, 1);
          2: drive(0, 1, 1);
          default: drive(0, 0, 1);
        endcase
        if ($signed(count) != expCnt) misses++;
        if (prev == 8'sd127) begin
          upSeen++;
          chk("R6 127 plus one wraps", $signed(count), -128);
        end
      end
    end
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic signed [CNT_W-1:0] prev;
        prev = expCnt;
        case (k)
          0: drive(0, 1, -1);
          1: drive(1, 1, -1);
          2: drive(1, 0, -1);
          default: drive(0, 0, -1);
        endcase
        if ($signed(count) != expCnt) misses++;
        if (prev == -8'sd128) begin
          dnSeen++;
          chk("R6 -128 minus one wraps", $signed(count), 127);
        end
      end
    end
    chk("R6 ring tracking mismatches", misses, 0);
    chk("R6 both crossings reached", upSeen * dnSeen, 1);
  endtask

  task automatic t_double;
    cfgMode = 2'd3;
    chk("R10 no error before double change", seqErr, 0);
    drive(1, 1, 0);
    chk("R10 double change not counted", $signed(count), expCnt);
    chk("R10 error set", seqErr, 1);
    drive(0, 0, 0);
    chk("R10 second double change not counted", $signed(count), expCnt);
    cfgMode = 2'd2;
    drive(1, 1, 0);
    drive(0, 0, 0);
    chk("R10 2x double change not counted", $signed(count), expCnt);
    chk("R10 error stays set", seqErr, 1);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    idle(4);
    t_reset();
    t_single();
    t_x1();
    t_x2();
    t_x4();
    t_compare();
    t_enable();
    t_filter();
    t_wrap();
    t_double();
    summary();
  end

endmodule